// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave side of a two-wire serial bus (clock and open-drain data) in front of a byte-wide memory. The memory has a 17-bit address space. The system clock oversamples both bus lines. The block finds Start and Stop conditions on the lines and checks the device select byte against a fixed type code and two strap pins. It then takes a two-byte word address, and either stores one data byte or streams bytes back to the master.

Each select byte carries the type code, the chip-select bits, the top address bit and the transfer direction. Up to four such slaves can share one bus, told apart by their strap pins. A write is committed to the array only when the master sends Stop. For a configurable number of system clocks after that, the slave models an internal write and ignores its own select byte.

A random read is a write-direction address phase, then a repeated Start, then a read-direction select byte. The storage is a behavioural array with a parameterised depth. When the array is smaller than the full address space, it keeps the top address bit plus the low address bits as its index.

Top module: `serial_mem_slave`

## Requirements
- R1: A select byte whose bits 7:4 differ from TYPE_CODE (default 4'b1010) gets no acknowledge. The slave stays silent until the next Start.
- R2: Select bits 3:2 must equal strap_i[1:0] (bit 3 against strap_i[1]), or the byte gets no acknowledge.
- R3: For each accepted byte, the slave pulls SDA low from the SCL fall after the eighth data bit until the SCL fall after the ninth clock. Accepted bytes are the select byte, both word-address bytes and the first data byte. A second data byte in one write gets no acknowledge.
- R4: The memory address is built as follows: bit 1 of the select byte gives A16, the first word-address byte gives A15..A8, and the second gives A7..A0.
- R5: Bit 0 of the select byte picks the direction: 1 is read, 0 is write.
- R6: A write sequence with a data byte changes the array only when the following Stop arrives, at the loaded address.
- R7: A Start seen at any point drops the current transfer, discards an uncommitted data byte and returns to receiving a select byte.
- R8: For WRITE_CLKS system clocks after a committing Stop, a matching select byte gets no acknowledge. After that time it is acknowledged again.
- R9: Read data leaves MSB first. A master acknowledge (SDA low on the ninth clock) makes the slave send the byte at the next address. A master non-acknowledge makes it release SDA until Start or Stop.
- R10: A read-direction select byte after a repeated Start reads from the address loaded by the preceding write-direction phase, with A16 taken from the new select byte.
- R11: sda_pull_o changes only while SCL is low. Start is SDA falling with SCL high, and Stop is SDA rising with SCL high.
- R12: In reset and after it, until addressed, sda_pull_o is 0.
- R13: The address counter rolls over from 0x1FFFF to 0x00000 during a sequential read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| strap_i | input | 2 | Chip-select strap pins matched against select bits 3:2 |
| sda_pull_o | output | 1 | 1 pulls the open-drain data line low |

## Verification
A table of address/data pairs is written with byte writes and read back with random reads. The table includes two addresses that differ only in A16, so a lost top bit shows up as aliasing, and three consecutive addresses that a sequential read then walks. Select bytes with a wrong type code, a wrong strap value, or sent during the write time must each draw no acknowledge. This separates the three reasons to stay silent. Directed sequences then show three more behaviours: a repeated Start after a data byte leaves the old value in place, a second data byte is refused, and a sequential read across 0x1FFFF continues at 0x00000.

// File: rtl/sms_pkg.sv
package sms_pkg;
   localparam int ADDR_W = 17;
   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEV,
      ST_AHI,
      ST_ALO,
      ST_WDAT,
      ST_RD,
      ST_HOLD
   } sms_state_e;
endpackage

// File: rtl/sms_line_sync.sv
module sms_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det,
   output logic sda_s
);
   logic [STAGES-1:0] scl_sh, sda_sh;
   logic              scl_q, sda_q, scl_s;

   if (STAGES < 2) begin : g_bad_stages
      $error("STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_sh <= '1;
         sda_sh <= '1;
         scl_q  <= 1'b1;
         sda_q  <= 1'b1;
      end else begin
         scl_sh <= {scl_sh[STAGES-2:0], scl_i};
         sda_sh <= {sda_sh[STAGES-2:0], sda_i};
         scl_q  <= scl_sh[STAGES-1];
         sda_q  <= sda_sh[STAGES-1];
      end
   end

   assign scl_s     = scl_sh[STAGES-1];
   assign sda_s     = sda_sh[STAGES-1];
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_q & scl_s & sda_q & ~sda_s;
   assign stop_det  = scl_q & scl_s & ~sda_q & sda_s;
endmodule

// File: rtl/sms_mem.sv
module sms_mem
   import sms_pkg::*;
#(
   parameter int DEPTH = 512
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [BYTE_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [BYTE_W-1:0] rdata
);
   localparam int IDX_W = $clog2(DEPTH);

   logic [IDX_W-1:0]  widx, ridx;
   logic [BYTE_W-1:0] arr [DEPTH];

   if (DEPTH == 2**ADDR_W) begin : g_full
      assign widx = waddr;
      assign ridx = raddr;
   end else begin : g_fold
      logic unused_mid;
      assign widx = {waddr[ADDR_W-1], waddr[IDX_W-2:0]};
      assign ridx = {raddr[ADDR_W-1], raddr[IDX_W-2:0]};
      assign unused_mid = ^{waddr[ADDR_W-2:IDX_W-1], raddr[ADDR_W-2:IDX_W-1]};
   end

   always_ff @(posedge clk) begin
      if (we) arr[widx] <= wdata;
   end

   assign rdata = arr[ridx];
endmodule

// File: rtl/sms_ctrl.sv
module sms_ctrl
   import sms_pkg::*;
#(
   parameter logic [3:0] TYPE_CODE  = 4'b1010,
   parameter int         WRITE_CLKS = 2000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic              sda_s,
   input  logic [1:0]        strap,
   input  logic [BYTE_W-1:0] rd_data,
   output logic              sda_pull,
   output logic              mem_we,
   output logic [ADDR_W-1:0] addr,
   output logic [BYTE_W-1:0] wdat,
   output logic              busy,
   output sms_state_e        state,
   output logic [3:0]        bit_cnt
);
   localparam int TW = $clog2(WRITE_CLKS + 1);

   logic [TW-1:0]     wr_timer;
   logic [BYTE_W-1:0] sh, tx;
   logic              ninth, rd_mode, pend, m_ack, dev_ok, rx_state;

   assign busy     = (wr_timer != '0);
   assign dev_ok   = (sh[7:4] == TYPE_CODE) && (sh[3:2] == strap) && !busy;
   assign rx_state = state inside {ST_DEV, ST_AHI, ST_ALO, ST_WDAT};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         bit_cnt  <= '0;
         ninth    <= 1'b0;
         sda_pull <= 1'b0;
         pend     <= 1'b0;
         rd_mode  <= 1'b0;
         m_ack    <= 1'b0;
         mem_we   <= 1'b0;
         addr     <= '0;
         wdat     <= '0;
         sh       <= '0;
         tx       <= '0;
         wr_timer <= '0;
      end else begin
         mem_we <= 1'b0;
         if (busy) wr_timer <= wr_timer - 1'b1;
         if (start_det) begin
            state    <= ST_DEV;
            bit_cnt  <= '0;
            ninth    <= 1'b0;
            sda_pull <= 1'b0;
            pend     <= 1'b0;
         end else if (stop_det) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            ninth    <= 1'b0;
            sda_pull <= 1'b0;
            if (pend) begin
               mem_we   <= 1'b1;
               wr_timer <= TW'(WRITE_CLKS);
               pend     <= 1'b0;
            end
         end else if (state == ST_RD) begin
            if (scl_rise) begin
               if (bit_cnt == 4'd8) begin
                  ninth <= 1'b1;
                  m_ack <= ~sda_s;
               end else begin
                  bit_cnt <= bit_cnt + 4'd1;
               end
            end else if (scl_fall) begin
               if (ninth) begin
                  ninth   <= 1'b0;
                  bit_cnt <= '0;
                  if (m_ack) begin
                     tx       <= rd_data;
                     sda_pull <= ~rd_data[7];
                  end else begin
                     state <= ST_HOLD;
                  end
               end else if (bit_cnt == 4'd8) begin
                  sda_pull <= 1'b0;
                  addr     <= addr + 1'b1;
               end else if (bit_cnt != 4'd0) begin
                  sda_pull <= ~tx[6];
                  tx       <= {tx[6:0], 1'b0};
               end
            end
         end else if (rx_state) begin
            if (scl_rise) begin
               if (bit_cnt == 4'd8) begin
                  ninth <= 1'b1;
               end else begin
                  sh      <= {sh[6:0], sda_s};
                  bit_cnt <= bit_cnt + 4'd1;
               end
            end else if (scl_fall && bit_cnt == 4'd8) begin
               if (!ninth) begin
                  if (state != ST_DEV) begin
                     sda_pull <= 1'b1;
                  end else if (dev_ok) begin
                     sda_pull <= 1'b1;
                     addr[ADDR_W-1] <= sh[1];
                     rd_mode  <= sh[0];
                  end else begin
                     state   <= ST_IDLE;
                     bit_cnt <= '0;
                  end
               end else begin
                  ninth    <= 1'b0;
                  bit_cnt  <= '0;
                  sda_pull <= 1'b0;
                  case (state)
                     ST_DEV: begin
                        if (rd_mode) begin
                           state    <= ST_RD;
                           tx       <= rd_data;
                           sda_pull <= ~rd_data[7];
                        end else begin
                           state <= ST_AHI;
                        end
                     end
                     ST_AHI: begin
                        addr[15:8] <= sh;
                        state      <= ST_ALO;
                     end
                     ST_ALO: begin
                        addr[7:0] <= sh;
                        state     <= ST_WDAT;
                     end
                     default: begin
                        wdat  <= sh;
                        pend  <= 1'b1;
                        state <= ST_HOLD;
                     end
                  endcase
               end
            end
         end
      end
   end
endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave
   import sms_pkg::*;
#(
   parameter int         DEPTH       = 512,
   parameter int         WRITE_CLKS  = 2000,
   parameter int         SYNC_STAGES = 2,
   parameter logic [3:0] TYPE_CODE   = 4'b1010
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   input  logic [1:0] strap_i,
   output logic       sda_pull_o
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0 || DEPTH > 2**ADDR_W) begin : g_bad_depth
      $error("DEPTH must be a power of two from 2 to 2**17");
   end
   if (WRITE_CLKS < 1) begin : g_bad_wclks
      $error("WRITE_CLKS must be at least 1");
   end

   logic              scl_rise, scl_fall, start_det, stop_det, sda_s;
   logic              mem_we, busy;
   logic [ADDR_W-1:0] addr;
   logic [BYTE_W-1:0] wdat, rd_data;
   logic [3:0]        bit_cnt;
   sms_state_e        state;

   sms_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .sda_s     (sda_s)
   );

   sms_ctrl #(.TYPE_CODE(TYPE_CODE), .WRITE_CLKS(WRITE_CLKS)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .sda_s     (sda_s),
      .strap     (strap_i),
      .rd_data   (rd_data),
      .sda_pull  (sda_pull_o),
      .mem_we    (mem_we),
      .addr      (addr),
      .wdat      (wdat),
      .busy      (busy),
      .state     (state),
      .bit_cnt   (bit_cnt)
   );

   sms_mem #(.DEPTH(DEPTH)) u_mem (
      .clk   (clk),
      .we    (mem_we),
      .waddr (addr),
      .wdata (wdat),
      .raddr (addr),
      .rdata (rd_data)
   );
endmodule

// File: rtl/sms_chk.sv
module sms_chk
   import sms_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       scl_i,
   input logic       sda_pull,
   input logic       start_det,
   input logic       stop_det,
   input logic       mem_we,
   input logic       busy,
   input sms_state_e st,
   input logic [3:0] bit_cnt
);
   // R11
   pull_moves_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_pull != $past(sda_pull)) |-> !scl_i);

   // R8
   busy_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !sda_pull);

   // R6
   commit_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> $past(stop_det));

   // R7
   start_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (st == ST_DEV && bit_cnt == 4'd0 && !sda_pull));

   // R1
   idle_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> !sda_pull);

   // R3
   bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= 4'd8);
endmodule

bind serial_mem_slave sms_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .scl_i     (scl_i),
   .sda_pull  (sda_pull_o),
   .start_det (start_det),
   .stop_det  (stop_det),
   .mem_we    (mem_we),
   .busy      (busy),
   .st        (state),
   .bit_cnt   (bit_cnt)
);

// File: tb/serial_mem_slave_tb.sv
module serial_mem_slave_tb;
   localparam int WR = 2000;
   localparam int Q  = 10;
   localparam logic [1:0] STRAP = 2'b10;
   localparam int NV = 6;
   localparam logic [24:0] VEC [NV] = '{
      {17'h00010, 8'h3C}, {17'h00011, 8'hC3}, {17'h00012, 8'h81},
      {17'h10010, 8'h7E}, {17'h05A5A, 8'hE7}, {17'h0ABCD, 8'h00}
   };

   logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, done = 1'b0;
   logic sda_pull_o, sda_line, prev_pull = 1'b0;
   int   n_chk = 0, n_bad = 0, r11_viol = 0;

   always #10 clk = ~clk;
   assign sda_line = sda_m & ~sda_pull_o;

   serial_mem_slave #(.DEPTH(512), .WRITE_CLKS(WR)) u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .strap_i(STRAP), .sda_pull_o(sda_pull_o));

   // R11: output may only move while SCL is low
   always @(negedge clk) begin
      if (rst_n && scl_m && sda_pull_o != prev_pull) r11_viol++;
      prev_pull <= sda_pull_o;
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
   endtask

   task automatic send(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; wq(); scl_m = 1'b1; wq(); scl_m = 1'b0; wq();
      end
      sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
      ack = ~sda_line;
      scl_m = 1'b0; wq();
   endtask

   task automatic recv(input logic mack, output logic [7:0] d);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         wq(); scl_m = 1'b1; wq(); d[i] = sda_line; scl_m = 1'b0;
      end
      wq(); sda_m = ~mack; wq(); scl_m = 1'b1; wq(); scl_m = 1'b0; wq(); sda_m = 1'b1;
   endtask

   function automatic logic [7:0] dev(input logic a16, input logic rd);
      return {4'b1010, STRAP, a16, rd};
   endfunction

   task automatic addr_phase(input logic [16:0] a, output logic [2:0] acks);
      bus_start();
      send(dev(a[16], 1'b0), acks[2]);
      send(a[15:8], acks[1]);
      send(a[7:0], acks[0]);
   endtask

   task automatic do_write(input logic [16:0] a, input logic [7:0] d, input string tag);
      logic [2:0] acks;
      logic       dack;
      addr_phase(a, acks);
      send(d, dack);
      bus_stop();
      check({tag, " R3 write acks"}, {acks, dack}, 4'hF);
      repeat (WR + 100) @(negedge clk);
   endtask

   task automatic rand_read(input logic [16:0] a, input logic mack, output logic [7:0] d);
      logic [2:0] acks;
      logic       rack;
      addr_phase(a, acks);
      bus_start();
      send(dev(a[16], 1'b1), rack);
      check("R5 read select acks", {acks, rack}, 4'hF);
      recv(mack, d);
   endtask

   initial begin
      logic [7:0] d, d2, d3;
      logic [2:0] acks;
      logic       ak;
      int         lows;
      repeat (5) @(negedge clk);
      check("R12 pull in reset", sda_pull_o, 1'b0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check("R12 pull after reset", sda_pull_o, 1'b0);

      // vector table: write every entry, then read every entry back
      for (int i = 0; i < NV; i++) do_write(VEC[i][24:8], VEC[i][7:0], "R6");
      for (int i = 0; i < NV; i++) begin
         rand_read(VEC[i][24:8], 1'b0, d);
         bus_stop();
         check("R4 R6 R10 readback", d, VEC[i][7:0]);
      end

      // R9: sequential read walks 0x10..0x12
      rand_read(17'h00010, 1'b1, d);
      recv(1'b1, d2);
      recv(1'b0, d3);
      check("R9 seq byte0", d, 8'h3C);
      check("R9 seq byte1", d2, 8'hC3);
      check("R9 seq byte2", d3, 8'h81);
      // R9: after non-acknowledge the line stays released
      lows = 0;
      for (int k = 0; k < 9; k++) begin
         wq(); scl_m = 1'b1; wq(); if (!sda_line) lows++; scl_m = 1'b0;
      end
      wq();
      bus_stop();
      check("R9 released after nack", lows, 0);

      // R1: wrong type code
      bus_start(); send({4'b1011, STRAP, 2'b00}, ak); bus_stop();
      check("R1 wrong type no ack", ak, 1'b0);
      // R2: wrong strap value
      bus_start(); send({4'b1010, 2'b01, 2'b00}, ak); bus_stop();
      check("R2 wrong strap no ack", ak, 1'b0);

      // R7: repeated Start after a data byte discards it
      addr_phase(17'h00011, acks);
      send(8'h55, ak);
      rand_read(17'h00011, 1'b0, d);
      bus_stop();
      check("R7 aborted write left old data", d, 8'hC3);

      // R3: second data byte is refused, first is kept
      addr_phase(17'h00040, acks);
      send(8'h11, ak);
      send(8'h22, d[0]);
      bus_stop();
      check("R3 second data byte no ack", d[0], 1'b0);
      // R8: select byte during internal write time is refused
      bus_start(); send(dev(1'b0, 1'b0), ak); bus_stop();
      check("R8 busy no ack", ak, 1'b0);
      repeat (WR + 100) @(negedge clk);
      bus_start(); send(dev(1'b0, 1'b0), ak); bus_stop();
      check("R8 ack after write time", ak, 1'b1);
      rand_read(17'h00040, 1'b0, d);
      bus_stop();
      check("R3 first data byte stored", d, 8'h11);

      // R13: roll over from top address to zero
      do_write(17'h1FFFF, 8'hA5, "R13");
      do_write(17'h00000, 8'h5A, "R13");
      rand_read(17'h1FFFF, 1'b1, d);
      recv(1'b0, d2);
      bus_stop();
      check("R13 top byte", d, 8'hA5);
      check("R13 wrapped byte", d2, 8'h5A);

      check("R11 pull moved while SCL high", r11_viol, 0);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule